// File: doc/BRIEF.md
# Serial Two-Channel Setting Register Front End

This block is the digital front end of a two-channel, 8-bit programmable voltage source. A host writes channel settings over a three-wire serial link made of a serial clock, a select line and a data input. The block keeps one volatile working register per channel and drives the setting buses directly from those registers. A nonvolatile shadow array, owned by a companion block, supplies the power-on and default values.

A transaction starts with a 1 bit. Two address bits follow, then eight data bits, and every field is sent least significant bit first. While the new value shifts in, the old contents of the addressed channel shift out on the serial data output. Every write is therefore also a read. When the select line falls, the temporary settings are dropped and every channel is loaded again from the shadow array. Short low pulses on the select line are filtered out, so they do not cause this reload. All serial inputs are synchronized to a fast system clock, and all logic runs in that clock domain.

Top module: `sdac_front`

## Requirements
- R1: A frame is a 1 start bit, then address bits A0 and A1, then data bits D0..D7. The address value is {A1,A0}: 0 selects channel 0 (set_o[7:0]) and 1 selects channel 1 (set_o[15:8]). The data byte is {D7..D0}.
- R2: Between frames, a 0 sampled on din_i is ignored. Only a 1 sampled on din_i begins a frame.
- R3: After the serial edge that samples A1, dout_o presents bit 0 of the addressed channel's previous value. After each of the edges that sample D0..D6, it presents the next higher bit. All 8 old bits are available before the D7 edge.
- R4: The addressed channel takes the new byte at the serial edge that samples D7. The change is visible before the next serial rising edge, and no other channel changes.
- R5: Address values 2 and 3 (A1=1) are reserved. Such a frame changes no channel, and dout_o returns 0 for all 8 bits.
- R6: dout_oe_o is high only while the filtered select is high. When it is low, the data output is treated as high impedance.
- R7: While the filtered select is low, every channel follows nv_set_i. This includes the state after reset and the state after the select line falls.
- R8: A low pulse on cs_i that lasts fewer than FILT_CYC system clock cycles is ignored. The volatile settings are kept.
- R9: The two serial rising edges that follow D7 are a mandatory gap. A 1 sampled in that gap does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_i | input | 1 | Select, active high; a low level reloads the shadow values |
| din_i | input | 1 | Serial data input |
| nv_set_i | input | 16 | Nonvolatile shadow values, channel 0 in the low byte |
| set_o | output | 16 | Channel setting buses, channel 0 in the low byte |
| dout_o | output | 1 | Serial read-back data |
| dout_oe_o | output | 1 | Output enable for dout_o |

## Verification
A wrong frame counter or a wrong address register shows on the same transaction. Either the wrong channel bus changes at the D7 edge, or dout_o returns a byte that differs from the value the bench last wrote. Gap-length and idle-state faults show on the frame that comes next, because a misaligned start puts the next write on a reserved address or on the wrong channel. Select-filter and reload faults show on set_o within a few system clock cycles after a select pulse: either the settings reload on a glitch, or they stay volatile after a real deselect.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GAP
  } frm_state_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/sdac_cs_filter.sv
module sdac_cs_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic cs_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          cs_q;
  logic [CW-1:0] cnt_q;

  // level must disagree for FILT_CYC consecutive cycles before it is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      cnt_q <= '0;
    end else if (cs_i == cs_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      cs_q  <= cs_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cs_o = cs_q;
endmodule

// File: rtl/sdac_deframer.sv
module sdac_deframer
  import sdac_pkg::*;
#(
  parameter int W         = 8,
  parameter int AW        = 2,
  parameter int NCH       = 2,
  parameter int GAP_EDGES = 2,
  parameter int CHW       = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  step_i,
  input  logic                  din_i,
  input  logic [NCH-1:0][W-1:0] cur_i,
  output logic                  wr_stb_o,
  output logic [CHW-1:0]        wr_ch_o,
  output logic [W-1:0]          wr_data_o,
  output logic                  dout_o
);
  localparam int CNTW = $clog2(W + AW + GAP_EDGES + 1);
  localparam logic [AW:0] NCH_L = (AW + 1)'(NCH);

  frm_state_e      state_q;
  logic [CNTW-1:0] cnt_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   nxt_addr;
  logic [W-1:0]    in_sr_q;
  logic [W-1:0]    out_sr_q;
  logic [W-1:0]    rd_val;
  logic            nxt_ok;
  logic            addr_ok;

  assign nxt_addr = {din_i, addr_q[AW-1:1]};
  assign nxt_ok   = {1'b0, nxt_addr} < NCH_L;
  assign addr_ok  = {1'b0, addr_q} < NCH_L;
  assign rd_val   = nxt_ok ? cur_i[nxt_addr[CHW-1:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      addr_q   <= '0;
      in_sr_q  <= '0;
      out_sr_q <= '0;
    end else if (!en_i) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      out_sr_q <= '0;
    end else if (step_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (din_i) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
          end
        end
        ST_ADDR: begin
          addr_q <= nxt_addr;
          if (cnt_q == CNTW'(AW - 1)) begin
            state_q  <= ST_DATA;
            cnt_q    <= '0;
            out_sr_q <= rd_val;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          in_sr_q  <= {din_i, in_sr_q[W-1:1]};
          out_sr_q <= {1'b0, out_sr_q[W-1:1]};
          if (cnt_q == CNTW'(W - 1)) begin
            state_q <= ST_GAP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_q == CNTW'(GAP_EDGES - 1)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_stb_o  = en_i & step_i & (state_q == ST_DATA) &
                     (cnt_q == CNTW'(W - 1)) & addr_ok;
  assign wr_ch_o   = addr_q[CHW-1:0];
  assign wr_data_o = {din_i, in_sr_q[W-1:1]};
  assign dout_o    = out_sr_q[0];
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int W           = 8,
  parameter int NCH         = 2,
  parameter int AW          = 2,
  parameter int GAP_EDGES   = 2,
  parameter int FILT_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_i,
  input  logic             din_i,
  input  logic [NCH*W-1:0] nv_set_i,
  output logic [NCH*W-1:0] set_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                  cs_s, sclk_s, din_s;
  logic                  sclk_prev;
  logic                  sclk_rise;
  logic                  cs_f;
  logic                  wr_stb;
  logic [CHW-1:0]        wr_ch;
  logic [W-1:0]          wr_data;
  logic                  df_dout;
  logic [NCH-1:0][W-1:0] nv_arr;
  logic [NCH-1:0][W-1:0] work_q;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sclk_i, din_i}),
    .q_o   ({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev <= 1'b0;
    else         sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;

  sdac_cs_filter #(.FILT_CYC(FILT_CYC)) u_csf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs_s),
    .cs_o  (cs_f)
  );

  sdac_deframer #(
    .W(W), .AW(AW), .NCH(NCH), .GAP_EDGES(GAP_EDGES), .CHW(CHW)
  ) u_dfr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cs_f),
    .step_i   (sclk_rise),
    .din_i    (din_s),
    .cur_i    (work_q),
    .wr_stb_o (wr_stb),
    .wr_ch_o  (wr_ch),
    .wr_data_o(wr_data),
    .dout_o   (df_dout)
  );

  assign nv_arr = nv_set_i;

  // deselected: working registers shadow the nonvolatile array
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     work_q <= '0;
    else if (!cs_f)  work_q <= nv_arr;
    else if (wr_stb) work_q[wr_ch] <= wr_data;
  end

  assign set_o     = work_q;
  assign dout_oe_o = cs_f;
  assign dout_o    = cs_f & df_dout;
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_sync,
  input logic             cs_filt,
  input logic             rise_p,
  input logic [NCH*W-1:0] nv_set_i,
  input logic [NCH*W-1:0] set_o
);
  logic [NCH*W-1:0] set_d;
  logic [NCH-1:0]   chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) set_d <= '0;
    else         set_d <= set_o;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chg
    assign chg[g] = set_o[g*W +: W] != set_d[g*W +: W];
  end

  AST_RELOAD_NV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_filt |=> set_o == $past(nv_set_i)); // R7

  AST_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_filt) |-> $onehot0(chg)); // R4

  AST_UPD_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_filt) && (set_o != set_d)) |-> $past(rise_p)); // R4

  AST_CS_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_filt != $past(cs_filt)) |-> ($past(cs_sync) == cs_filt)); // R8
endmodule

bind sdac_front sdac_front_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_sync (cs_s),
  .cs_filt (cs_f),
  .rise_p  (sclk_rise),
  .nv_set_i(nv_set_i),
  .set_o   (set_o)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0;
  logic        cs = 1'b0;
  logic        din = 1'b0;
  logic [15:0] nv = 16'hC35A;
  logic [15:0] set;
  logic        dout, dout_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] expv [2];

  always #5 clk = ~clk;

  sdac_front u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_i(cs), .din_i(din),
    .nv_set_i(nv), .set_o(set), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit; returns dout sampled well after the rising edge
  task automatic sbit(input logic b, output logic q);
    din  = b;
    sclk = 1'b0;
    wait_clk(8);
    sclk = 1'b1;
    wait_clk(8);
    q = dout;
  endtask

  task automatic frame(input int a, input logic [7:0] v, input logic gapb);
    logic       q;
    logic [7:0] rd;
    logic [7:0] old;
    logic [7:0] other;
    old   = (a < 2) ? expv[a] : 8'h00;
    other = (a == 0) ? expv[1] : expv[0];
    sbit(1'b1, q);
    sbit(a[0], q);
    sbit(a[1], q);
    rd[0] = q;
    for (int i = 0; i < 8; i++) begin
      sbit(v[i], q);
      if (i < 7) rd[i+1] = q;
    end
    if (a < 2) begin
      chk("R3 readback", {24'h0, rd}, {24'h0, old});
      chk("R4 update", {24'h0, set[a*8 +: 8]}, {24'h0, v});
      chk("R4 other", {24'h0, set[(1-a)*8 +: 8]}, {24'h0, other});
      expv[a] = v;
    end else begin
      chk("R5 reserved rd", {24'h0, rd}, 32'h0);
      chk("R5 reserved set", {16'h0, set}, {16'h0, expv[1], expv[0]});
    end
    sbit(gapb, q);
    sbit(gapb, q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic q;
    wait_clk(10);
    chk("R6 oe in reset", {31'h0, dout_oe}, 32'h0);
    rst_ni = 1'b1;
    wait_clk(6);
    chk("R7 nv after reset", {16'h0, set}, {16'h0, nv});
    chk("R6 oe deselected", {31'h0, dout_oe}, 32'h0);

    cs = 1'b1;
    wait_clk(20);
    chk("R6 oe selected", {31'h0, dout_oe}, 32'h1);
    expv[0] = nv[7:0];
    expv[1] = nv[15:8];

    // R1 R3 R4 sweep over values on both channels
    for (int v = 0; v < 256; v += 5) begin
      for (int c = 0; c < 2; c++) frame(c, (c == 1) ? ~8'(v) : 8'(v), 1'b0);
    end

    // R2 idle zeros ignored
    for (int i = 0; i < 6; i++) sbit(1'b0, q);
    chk("R2 idle zeros", {16'h0, set}, {16'h0, expv[1], expv[0]});
    frame(0, 8'h81, 1'b0);

    // R5 reserved addresses
    frame(2, 8'h77, 1'b0);
    frame(3, 8'h11, 1'b0);

    // R9 ones during the gap must not start a frame
    frame(0, 8'h3C, 1'b1);
    frame(1, 8'hA5, 1'b0);
    chk("R9 gap ch1", {24'h0, set[15:8]}, 32'hA5);
    chk("R9 gap ch0", {24'h0, set[7:0]}, 32'h3C);

    // R8 short select glitch
    cs = 1'b0;
    wait_clk(2);
    cs = 1'b1;
    wait_clk(20);
    chk("R8 glitch kept", {16'h0, set}, {16'h0, 16'hA53C});
    chk("R8 glitch oe", {31'h0, dout_oe}, 32'h1);

    // R7 real deselect reloads, tracks the shadow
    cs = 1'b0;
    wait_clk(20);
    chk("R7 reload", {16'h0, set}, {16'h0, nv});
    chk("R6 oe off", {31'h0, dout_oe}, 32'h0);
    nv = 16'h1E96;
    wait_clk(5);
    chk("R7 track nv", {16'h0, set}, 32'h1E96);
    cs = 1'b1;
    wait_clk(20);
    expv[0] = 8'h96;
    expv[1] = 8'h1E;
    frame(1, 8'h42, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule